// File: doc/BRIEF.md
# Five-Port Mesh Router Node

This block is one node of a two-dimensional mesh network. It has five byte-wide input ports and five byte-wide output ports, one pair for each neighbour (north, east, south, west) and one for the local processing element. The low three bits of every incoming byte name the output port it must leave on. That code is decoded once, when the byte enters. The result travels with the byte, so no later stage looks at the address bits again. Bytes with a code that names no port are dropped, and the input that sent them reports an error.

An accepted byte waits in a per-input holding register. For each output, a rotating arbiter picks one of the holding registers that target it, and the chosen byte is written into that output's region of a shared buffer. The buffer is split into five fixed FIFO regions: the local region sits at the bottom of the address space and the north region at the top. On every enabled cycle, each output presents the head of its region with a valid strobe and retires it. A global enable freezes the whole node when low. A synchronous reset clears it.

Top module: `mesh_router5`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every output valid and every input error flag is 0. With enable high, every input ready is 1.
- R2: Port indices are 0 north, 1 east, 2 south, 3 west, 4 local. A byte sits in bits [8i+7:8i] of the data buses. A byte whose low three bits equal p (0 to 4) is accepted on an edge where its input has valid, ready and enable high. If it is the only byte headed for p, it appears unchanged on output p with valid high during the second cycle after acceptance, for exactly one cycle.
- R3: A byte accepted with code 5, 6 or 7 produces no output. Its input's error flag is high for exactly the cycle after acceptance.
- R4: While enable is low, every input ready and every output valid is 0, and no internal state changes. Once enable returns high, pending bytes come out in the order they would have without the pause.
- R5: Each output has its own round-robin arbiter over the five holding registers. After reset, north has the highest priority. After a grant, priority runs clockwise from the port after the winner (north, east, south, west, local), so the winner becomes lowest.
- R6: An input whose held byte is not granted this cycle drives ready low. Its held byte is neither lost nor duplicated.
- R7: Each output emits at most one byte per cycle and holds valid low when its region is empty. Across any traffic, every accepted byte with a valid code leaves its coded output exactly once, in grant order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; low freezes the node |
| in_data | input | 40 | Five input bytes, port i at [8i+7:8i] |
| in_valid | input | 5 | Byte present on input i |
| in_ready | output | 5 | Input i can take a byte this cycle |
| in_err | output | 5 | Input i had a byte with an invalid code accepted on the previous edge |
| out_data | output | 40 | Five output bytes, port o at [8o+7:8o] |
| out_valid | output | 5 | Output o carries a byte this cycle |

## Verification
Single bytes sent one at a time to each code show the decode and the two-cycle latency without any contention. Five inputs aimed at one output in the same cycle, repeated, show the clockwise grant order and its rotation. They also show ready falling on the losers while their bytes wait. Invalid codes and enable-low windows separate dropping and freezing from normal forwarding. Long seeded random traffic with random enable checks ordering and conservation under mixed contention against a cycle-level bench model.

// File: rtl/mesh_router5.sv
module mesh_router5 #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [5*W-1:0] in_data,
  input  logic [4:0]   in_valid,
  output logic [4:0]   in_ready,
  output logic [4:0]   in_err,
  output logic [5*W-1:0] out_data,
  output logic [4:0]   out_valid
);
  localparam int N  = 5;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  hold_d   [N];
  logic [2:0]    hold_dst [N];
  logic [N-1:0]  hold_v;
  logic [W-1:0]  store [N*DEPTH];
  logic [AW-1:0] wp [N];
  logic [AW-1:0] rp [N];
  logic [CW-1:0] cnt [N];
  logic [2:0]    last [N];
  logic [2:0]    win [N];
  logic [W-1:0]  push_d [N];
  logic [N-1:0]  push, pop, room, won, code_ok, accept;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_port
      assign code_ok[g]  = in_data[g*W +: 3] < 3'd5;
      assign accept[g]   = in_valid[g] & in_ready[g];
      assign in_ready[g] = en & (~hold_v[g] | won[g]);
      assign pop[g]      = en & (cnt[g] != '0);
      assign room[g]     = (cnt[g] < CW'(DEPTH)) | pop[g];
      assign out_valid[g] = pop[g];
      assign out_data[g*W +: W] = store[(N-1-g)*DEPTH + int'(rp[g])];
    end
  endgenerate

  always_comb begin
    logic fnd;
    int   idx;
    won  = '0;
    push = '0;
    for (int o = 0; o < N; o++) begin
      push_d[o] = '0;
      win[o]    = '0;
      fnd       = 1'b0;
      for (int k = 1; k <= N; k++) begin
        idx = (int'(last[o]) + k) % N;
        if (!fnd && en && room[o] && hold_v[idx] && hold_dst[idx] == 3'(o)) begin
          fnd       = 1'b1;
          won[idx]  = 1'b1;
          push_d[o] = hold_d[idx];
          win[o]    = 3'(idx);
        end
      end
      push[o] = fnd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= '0;
      in_err <= '0;
      for (int i = 0; i < N; i++) begin
        hold_d[i]   <= '0;
        hold_dst[i] <= '0;
      end
    end else begin
      in_err <= accept & ~code_ok;
      if (en)
        for (int i = 0; i < N; i++) begin
          if (accept[i] && code_ok[i]) begin
            hold_v[i]   <= 1'b1;
            hold_d[i]   <= in_data[i*W +: W];
            hold_dst[i] <= in_data[i*W +: 3];
          end else if (won[i]) begin
            hold_v[i] <= 1'b0;
          end
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < N; o++) begin
        wp[o]   <= '0;
        rp[o]   <= '0;
        cnt[o]  <= '0;
        last[o] <= 3'(N-1);
      end
    end else begin
      for (int o = 0; o < N; o++) begin
        if (push[o]) begin
          wp[o]   <= (int'(wp[o]) == DEPTH-1) ? '0 : wp[o] + 1'b1;
          last[o] <= win[o];
        end
        if (pop[o])
          rp[o] <= (int'(rp[o]) == DEPTH-1) ? '0 : rp[o] + 1'b1;
        if (push[o] && !pop[o])
          cnt[o] <= cnt[o] + 1'b1;
        else if (!push[o] && pop[o])
          cnt[o] <= cnt[o] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < N; o++)
      if (push[o])
        store[(N-1-o)*DEPTH + int'(wp[o])] <= push_d[o];
  end
endmodule

// File: rtl/mesh_router5_checks.sv
module mesh_router5_checks #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [5*W-1:0] in_data,
  input logic [4:0]     in_valid,
  input logic [4:0]     in_ready,
  input logic [4:0]     in_err,
  input logic [5*W-1:0] out_data,
  input logic [4:0]     out_valid
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk)
    if (rst_d && !rst)
      p_quiet_after_reset_r1: assert (out_valid == '0 && in_err == '0);

  p_frozen_outputs_r4: assert property (@(posedge clk) disable iff (rst)
    !en |-> (out_valid == '0 && in_ready == '0));

  genvar g;
  generate
    for (g = 0; g < 5; g++) begin : g_chk
      p_out_code_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid[g] |-> out_data[g*W +: 3] == 3'(g));
      p_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
        in_err[g] |-> $past(in_valid[g] && in_ready[g] && in_data[g*W +: 3] >= 3'd5));
      p_err_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid[g] && in_ready[g] && in_data[g*W +: 3] >= 3'd5) |=> in_err[g]);
    end
  endgenerate
endmodule

bind mesh_router5 mesh_router5_checks #(.W(W)) u_checks (.*);

// File: tb/tb_mesh_router5.sv
module tb_mesh_router5;
  localparam int DEPTH = 4;
  logic clk = 0, rst = 1, en = 1;
  logic [39:0] in_data = '0;
  logic [4:0] in_valid = '0;
  logic [4:0] in_ready, in_err, out_valid;
  logic [39:0] out_data;

  mesh_router5 #(.W(8), .DEPTH(DEPTH)) dut (.*);

  always #4 clk = ~clk;

  int vectors = 0, fails = 0;
  string cur = "R1";
  logic [7:0] mq [5][$];
  logic [7:0] md [5];
  logic [2:0] mdst [5];
  logic       mh [5];
  int         mlast [5];
  logic [4:0] merr;
  int         eg [5];
  logic [4:0] exp_ready;

  task automatic model_reset();
    for (int i = 0; i < 5; i++) begin
      mq[i].delete(); mh[i] = 0; md[i] = 0; mdst[i] = 0; mlast[i] = 4;
    end
    merr = '0;
  endtask

  task automatic calc();
    for (int o = 0; o < 5; o++) begin
      eg[o] = -1;
      if (en && !rst)
        for (int k = 1; k <= 5; k++) begin
          int idx = (mlast[o] + k) % 5;
          if (eg[o] < 0 && mh[idx] && mdst[idx] == 3'(o)) eg[o] = idx;
        end
    end
    for (int i = 0; i < 5; i++) begin
      logic g = 0;
      for (int o = 0; o < 5; o++) if (eg[o] == i) g = 1;
      exp_ready[i] = en && (rst || !mh[i] || g);
    end
  endtask

  task automatic bad(string what, int act, int expv);
    fails++;
    $display("FAIL %s %s: got %0h expected %0h", cur, what, act, expv);
  endtask

  task automatic cycle();
    logic [4:0] ev;
    calc();
    #1;
    vectors++;
    for (int o = 0; o < 5; o++) begin
      ev[o] = en && !rst && mq[o].size() > 0;
      if (out_valid[o] !== ev[o]) bad($sformatf("out_valid[%0d]", o), out_valid[o], ev[o]);
      else if (ev[o] && out_data[o*8 +: 8] !== mq[o][0])
        bad($sformatf("out_data[%0d]", o), out_data[o*8 +: 8], mq[o][0]);
    end
    if (in_ready !== exp_ready) bad("in_ready", in_ready, exp_ready);
    if (in_err !== merr) bad("in_err", in_err, merr);
    @(posedge clk);
    if (rst) model_reset();
    else begin
      for (int i = 0; i < 5; i++)
        merr[i] = in_valid[i] && exp_ready[i] && in_data[i*8 +: 3] >= 3'd5;
      if (en) begin
        for (int o = 0; o < 5; o++) if (mq[o].size() > 0) void'(mq[o].pop_front());
        for (int o = 0; o < 5; o++)
          if (eg[o] >= 0) begin
            mq[o].push_back(md[eg[o]]); mh[eg[o]] = 0; mlast[o] = eg[o];
          end
        for (int i = 0; i < 5; i++)
          if (in_valid[i] && exp_ready[i] && in_data[i*8 +: 3] < 3'd5) begin
            mh[i] = 1; md[i] = in_data[i*8 +: 8]; mdst[i] = in_data[i*8 +: 3];
          end
      end
    end
    @(negedge clk);
  endtask

  task automatic send(int port, logic [4:0] hi, logic [2:0] code);
    in_valid[port] = 1;
    in_data[port*8 +: 8] = {hi, code};
  endtask

  task automatic idle(int n);
    in_valid = '0;
    for (int c = 0; c < n; c++) cycle();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    @(negedge clk);
    cur = "R1"; rst = 1; en = 1;
    send(0, 5'h11, 3'd2);
    for (int c = 0; c < 3; c++) cycle();
    rst = 0; in_valid = '0;
    idle(2);

    cur = "R2";
    for (int p = 0; p < 5; p++)
      for (int d = 0; d < 5; d++) begin
        send(p, 5'(p*5 + d), 3'(d));
        cycle();
        idle(3);
      end

    cur = "R5";
    for (int r = 0; r < 3; r++) begin
      for (int p = 0; p < 5; p++) send(p, 5'(r*8 + p), 3'd2);
      cycle();
      idle(7);
    end
    send(3, 5'h1a, 3'd4); send(1, 5'h1b, 3'd4);
    cycle();
    idle(4);

    cur = "R6";
    for (int c = 0; c < 10; c++) begin
      send(0, 5'(c), 3'd1); send(2, 5'(c + 16), 3'd1);
      cycle();
    end
    idle(6);

    cur = "R3";
    for (int c = 5; c < 8; c++) begin
      send(c - 5, 5'h0f, 3'(c)); send(4, 5'(c), 3'd0);
      cycle();
      idle(2);
    end

    cur = "R4";
    for (int p = 0; p < 5; p++) send(p, 5'(p), 3'd3);
    cycle();
    en = 0;
    for (int c = 0; c < 4; c++) cycle();
    for (int p = 0; p < 5; p++) send(p, 5'h1f, 3'd6);
    cycle();
    en = 1; in_valid = '0;
    idle(8);

    cur = "R7";
    for (int c = 0; c < 3000; c++) begin
      en = ($urandom_range(0, 9) != 0);
      for (int p = 0; p < 5; p++) begin
        in_valid[p] = ($urandom_range(0, 2) != 0);
        in_data[p*8 +: 8] = 8'($urandom);
        if ($urandom_range(0, 7) != 0) in_data[p*8 +: 3] = 3'($urandom_range(0, 4));
      end
      cycle();
    end
    en = 1;
    idle(10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule